// File: doc/BRIEF.md
# UART Diagnostic Loop-Back Router

This block sits between a UART core and the chip's serial and modem pins. It has two jobs. In normal operation it passes serial data straight through, it drives the four modem-control outputs from their register bits, and it synchronizes the four external modem-status inputs before the status logic uses them. In diagnostic loop-back mode it cuts the pins away and wraps the core back on itself. The transmitter's serial stream goes straight into the receiver. The TX pin rests at mark. The modem-control outputs go inactive. Each modem-control register bit takes the place of one modem-status input.

The block also keeps a sticky change flag for each status line. The CTS, DSR and CD flags set on any change of the value that the status logic sees. The RI flag sets only when RI goes from 1 to 0. A read of the modem-status register clears every flag. These flags follow the value after the mode mux, so a mode switch that changes that value is also reported as a change.

Top module: `uart_loopback_router`

## Requirements
- R1: When `loop_en` is 0, `tx_pin` equals `ser_tx_core` and `rx_core` equals `rx_pin` in the same cycle.
- R2: When `loop_en` is 1, `rx_core` equals `ser_tx_core` and `rx_pin` has no effect on it.
- R3: When `loop_en` is 1, `tx_pin` is held at 1 (mark).
- R4: `mctl_pins` equals `mctl_bits` when `loop_en` is 0 and is 4'b0000 when `loop_en` is 1.
- R5: Status vectors use bit 0 = CTS, bit 1 = DSR, bit 2 = RI, bit 3 = CD. When `loop_en` is 1, `status_now` equals `mctl_bits` in the same cycle: DTR (bit 0) drives CTS, RTS (bit 1) drives DSR, bit 2 drives RI and bit 3 drives CD. `ext_status` has no effect in this mode.
- R6: When `loop_en` is 0, `status_now` shows an `ext_status` value after two rising clock edges (two-flop synchronizer).
- R7: Any change of `status_now` bit 0, 1 or 3 sets the matching bit of `status_delta` on the next rising edge.
- R8: `status_delta` bit 2 sets only when `status_now` bit 2 falls from 1 to 0. A rising RI sets no flag.
- R9: A set `status_delta` bit stays set until an edge at which `status_rd` is 1. That edge clears every bit that has no new change.
- R10: A change that is detected at the same edge as a read sets its flag. Setting takes priority over clearing.
- R11: While `rst_n` is 0, `status_delta` is 0 and the synchronizer and previous-status registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_en | input | 1 | Diagnostic loop-back enable |
| mctl_bits | input | 4 | Modem-control register bits: 0 DTR, 1 RTS, 2 aux, 3 interrupt enable |
| ser_tx_core | input | 1 | Serial output of the transmitter |
| rx_pin | input | 1 | External serial receive pin |
| ext_status | input | 4 | External modem-status inputs, active high, bit order as in R5 |
| status_rd | input | 1 | Read strobe of the modem-status register |
| tx_pin | output | 1 | External serial transmit pin |
| rx_core | output | 1 | Serial input to the receiver |
| mctl_pins | output | 4 | External modem-control outputs, active high |
| status_now | output | 4 | Modem-status values seen by the status logic |
| status_delta | output | 4 | Sticky change flags |

## Verification
The bound checker covers the per-cycle routing in both modes: the serial pass-through and wrap, the TX mark level, the isolation of the control pins, and the mapping of control bits onto status lines. It also checks the two-edge synchronizer latency, the direction rule for each change event, that flags stay set until a read, and that setting wins when a change and a read meet. The bench scenarios show the end-to-end behaviour. These include the flag that appears when the mode is switched, an RI rise that leaves no flag, external inputs being ignored while looped, and the exact cycle at which each flag first becomes visible after a pin change.

// File: rtl/lb_pkg.sv
package lb_pkg;
  localparam int NUM_MODEM = 4;
  localparam int ST_CTS = 0;
  localparam int ST_DSR = 1;
  localparam int ST_RI  = 2;
  localparam int ST_CD  = 3;
  // Lines that flag only on a 1 -> 0 transition
  localparam logic [NUM_MODEM-1:0] TRAIL_ONLY = 4'b0100;

  typedef logic [NUM_MODEM-1:0] modem_vec_t;

  // Per-line change event: any toggle, or a trailing edge for masked lines
  function automatic modem_vec_t status_events(input modem_vec_t prev,
                                               input modem_vec_t now,
                                               input modem_vec_t trail_mask);
    modem_vec_t evt;
    for (int i = 0; i < NUM_MODEM; i++) begin
      evt[i] = trail_mask[i] ? (prev[i] & ~now[i]) : (prev[i] ^ now[i]);
    end
    return evt;
  endfunction
endpackage

// File: rtl/lb_sync.sv
module lb_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lb_route.sv
module lb_route
  import lb_pkg::*;
(
  input  logic       loop_en,
  input  modem_vec_t mctl_bits,
  input  logic       ser_tx_core,
  input  logic       rx_pin,
  input  modem_vec_t status_synced,
  output logic       tx_pin,
  output logic       rx_core,
  output modem_vec_t mctl_pins,
  output modem_vec_t status_now
);
  modem_vec_t wrapped;

  // Control bit to status line wrap map
  always_comb begin
    wrapped         = '0;
    wrapped[ST_CTS] = mctl_bits[0];
    wrapped[ST_DSR] = mctl_bits[1];
    wrapped[ST_RI]  = mctl_bits[2];
    wrapped[ST_CD]  = mctl_bits[3];
  end

  always_comb begin
    if (loop_en) begin
      tx_pin     = 1'b1;
      rx_core    = ser_tx_core;
      mctl_pins  = '0;
      status_now = wrapped;
    end else begin
      tx_pin     = ser_tx_core;
      rx_core    = rx_pin;
      mctl_pins  = mctl_bits;
      status_now = status_synced;
    end
  end
endmodule

// File: rtl/lb_delta.sv
module lb_delta
  import lb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  modem_vec_t status_now,
  input  logic       status_rd,
  output modem_vec_t status_prev,
  output modem_vec_t delta_evt,
  output modem_vec_t status_delta
);
  assign delta_evt = status_events(status_prev, status_now, TRAIL_ONLY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_prev  <= '0;
      status_delta <= '0;
    end else begin
      status_prev  <= status_now;
      status_delta <= (status_rd ? '0 : status_delta) | delta_evt;
    end
  end
endmodule

// File: rtl/uart_loopback_router.sv
module uart_loopback_router
  import lb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       loop_en,
  input  logic [3:0] mctl_bits,
  input  logic       ser_tx_core,
  input  logic       rx_pin,
  input  logic [3:0] ext_status,
  input  logic       status_rd,
  output logic       tx_pin,
  output logic       rx_core,
  output logic [3:0] mctl_pins,
  output logic [3:0] status_now,
  output logic [3:0] status_delta
);
  localparam int SYNC_STAGES = 2;

  modem_vec_t status_synced;
  modem_vec_t status_prev;
  modem_vec_t delta_evt;

  lb_sync #(.WIDTH(NUM_MODEM), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ext_status),
    .q     (status_synced)
  );

  lb_route u_route (
    .loop_en       (loop_en),
    .mctl_bits     (mctl_bits),
    .ser_tx_core   (ser_tx_core),
    .rx_pin        (rx_pin),
    .status_synced (status_synced),
    .tx_pin        (tx_pin),
    .rx_core       (rx_core),
    .mctl_pins     (mctl_pins),
    .status_now    (status_now)
  );

  lb_delta u_delta (
    .clk          (clk),
    .rst_n        (rst_n),
    .status_now   (status_now),
    .status_rd    (status_rd),
    .status_prev  (status_prev),
    .delta_evt    (delta_evt),
    .status_delta (status_delta)
  );
endmodule

// File: rtl/lb_router_chk.sv
module lb_router_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       loop_en,
  input logic [3:0] mctl_bits,
  input logic       ser_tx_core,
  input logic       rx_pin,
  input logic [3:0] ext_status,
  input logic       status_rd,
  input logic       tx_pin,
  input logic       rx_core,
  input logic [3:0] mctl_pins,
  input logic [3:0] status_now,
  input logic [3:0] status_delta,
  input logic [3:0] status_prev,
  input logic [3:0] delta_evt
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_NORMAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |-> (tx_pin == ser_tx_core && rx_core == rx_pin)); // R1
  AST_RX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> rx_core == ser_tx_core); // R2
  AST_TX_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> tx_pin); // R3
  AST_MCTL_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    mctl_pins == (loop_en ? 4'b0000 : mctl_bits)); // R4
  AST_LOOP_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> status_now == mctl_bits); // R5
  AST_SYNC_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_en && age >= 2'd2) |-> status_now == $past(ext_status, 2)); // R6
  AST_TOGGLE_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (delta_evt & 4'b1011) == ((status_now ^ status_prev) & 4'b1011)); // R7
  AST_RI_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
    delta_evt[2] |-> (status_prev[2] && !status_now[2])); // R8
  AST_RI_ROSE: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && $rose(status_delta[2])) |-> !$past(status_now[2])); // R8
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && !$past(status_rd)) |->
      ((status_delta & $past(status_delta)) == $past(status_delta))); // R9
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && $past(status_rd) && $past(delta_evt) == 4'b0000) |->
      status_delta == 4'b0000); // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1) |-> ((status_delta & $past(delta_evt)) == $past(delta_evt))); // R10

  always_comb begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (status_delta == 4'b0000 && status_prev == 4'b0000); // R11
    end
  end
endmodule

bind uart_loopback_router lb_router_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .loop_en      (loop_en),
  .mctl_bits    (mctl_bits),
  .ser_tx_core  (ser_tx_core),
  .rx_pin       (rx_pin),
  .ext_status   (ext_status),
  .status_rd    (status_rd),
  .tx_pin       (tx_pin),
  .rx_core      (rx_core),
  .mctl_pins    (mctl_pins),
  .status_now   (status_now),
  .status_delta (status_delta),
  .status_prev  (status_prev),
  .delta_evt    (delta_evt)
);

// File: tb/sim_uart_loopback_router.sv
`timescale 1ns/1ps
module sim_uart_loopback_router;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       loop_en = 1'b0;
  logic [3:0] mctl_bits = 4'b0000;
  logic       ser_tx_core = 1'b1;
  logic       rx_pin = 1'b1;
  logic [3:0] ext_status = 4'b0000;
  logic       status_rd = 1'b0;
  logic       tx_pin, rx_core;
  logic [3:0] mctl_pins, status_now, status_delta;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string      req;
    logic [13:0] obs;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  uart_loopback_router u0 (
    .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .mctl_bits(mctl_bits),
    .ser_tx_core(ser_tx_core), .rx_pin(rx_pin), .ext_status(ext_status),
    .status_rd(status_rd), .tx_pin(tx_pin), .rx_core(rx_core),
    .mctl_pins(mctl_pins), .status_now(status_now), .status_delta(status_delta)
  );

  // Driver side: push an expected observation, sampled by the monitor
  task automatic expect_obs(input string req, input logic tx, input logic rx,
                            input logic [3:0] mp, input logic [3:0] st,
                            input logic [3:0] dl);
    exp_t e;
    #1;
    e.req = req;
    e.obs = {tx, rx, mp, st, dl};
    q.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        exp_t e;
        logic [13:0] act;
        e = q.pop_front();
        act = {tx_pin, rx_core, mctl_pins, status_now, status_delta};
        checks++;
        if (act !== e.obs) begin
          errors++;
          $display("FAIL %s: actual tx=%b rx=%b mp=%b st=%b dl=%b expected tx=%b rx=%b mp=%b st=%b dl=%b",
                   e.req, act[13], act[12], act[11:8], act[7:4], act[3:0],
                   e.obs[13], e.obs[12], e.obs[11:8], e.obs[7:4], e.obs[3:0]);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic read_clear(input string req, input logic tx, input logic rx,
                            input logic [3:0] mp, input logic [3:0] st);
    status_rd = 1'b1;
    step(1);
    status_rd = 1'b0;
    expect_obs(req, tx, rx, mp, st, 4'b0000);
  endtask

  initial begin
    @(negedge clk);
    expect_obs("R11 reset", 1'b1, 1'b1, 4'b0000, 4'b0000, 4'b0000);
    step(2);
    rst_n = 1'b1;
    step(3);

    // R1 serial pass-through
    ser_tx_core = 1'b0; rx_pin = 1'b1;
    expect_obs("R1 pass a", 1'b0, 1'b1, 4'b0000, 4'b0000, 4'b0000);
    step(1);
    ser_tx_core = 1'b1; rx_pin = 1'b0;
    expect_obs("R1 pass b", 1'b1, 1'b0, 4'b0000, 4'b0000, 4'b0000);
    step(1);
    // R4 control pins follow register bits in normal mode
    mctl_bits = 4'b0101;
    expect_obs("R4 normal pins", 1'b1, 1'b0, 4'b0101, 4'b0000, 4'b0000);

    // R6 two-edge latency, R7 CTS flag one edge later
    step(1);
    ext_status = 4'b0001;
    expect_obs("R6 no edge", 1'b1, 1'b0, 4'b0101, 4'b0000, 4'b0000);
    step(1);
    expect_obs("R6 one edge", 1'b1, 1'b0, 4'b0101, 4'b0000, 4'b0000);
    step(1);
    expect_obs("R6 two edges", 1'b1, 1'b0, 4'b0101, 4'b0001, 4'b0000);
    step(1);
    expect_obs("R7 CTS flag", 1'b1, 1'b0, 4'b0101, 4'b0001, 4'b0001);

    // R9 sticky, then read clears
    step(2);
    expect_obs("R9 sticky", 1'b1, 1'b0, 4'b0101, 4'b0001, 4'b0001);
    step(1);
    read_clear("R9 read clear", 1'b1, 1'b0, 4'b0101, 4'b0001);

    // R8 RI rise gives no flag, fall does
    step(1);
    ext_status = 4'b0101;
    step(3);
    expect_obs("R8 RI rise", 1'b1, 1'b0, 4'b0101, 4'b0101, 4'b0000);
    step(1);
    ext_status = 4'b0001;
    step(3);
    expect_obs("R8 RI fall", 1'b1, 1'b0, 4'b0101, 4'b0001, 4'b0100);
    step(1);
    read_clear("R9 clear RI", 1'b1, 1'b0, 4'b0101, 4'b0001);

    // R7 DSR and CD
    step(1);
    ext_status = 4'b1011;
    step(3);
    expect_obs("R7 DSR CD", 1'b1, 1'b0, 4'b0101, 4'b1011, 4'b1010);
    step(1);
    read_clear("R9 clear DSR CD", 1'b1, 1'b0, 4'b0101, 4'b1011);

    // R10 change meets a read at the same edge
    step(1);
    ext_status = 4'b1010;
    step(2);
    status_rd = 1'b1;
    expect_obs("R10 before", 1'b1, 1'b0, 4'b0101, 4'b1010, 4'b0000);
    step(1);
    status_rd = 1'b0;
    expect_obs("R10 set wins", 1'b1, 1'b0, 4'b0101, 4'b1010, 4'b0001);
    step(1);
    expect_obs("R10 kept", 1'b1, 1'b0, 4'b0101, 4'b1010, 4'b0001);
    step(1);
    read_clear("R9 clear after R10", 1'b1, 1'b0, 4'b0101, 4'b1010);

    // Loop-back: R2 R3 R4 R5, mode switch flags prev 1010 -> 0101
    step(1);
    loop_en = 1'b1; ser_tx_core = 1'b0; rx_pin = 1'b1;
    expect_obs("R5 loop map", 1'b1, 1'b0, 4'b0000, 4'b0101, 4'b0000);
    step(1);
    expect_obs("R7 mode switch", 1'b1, 1'b0, 4'b0000, 4'b0101, 4'b1011);
    step(1);
    read_clear("R9 clear loop", 1'b1, 1'b0, 4'b0000, 4'b0101);
    step(1);
    rx_pin = 1'b0; ser_tx_core = 1'b1;
    expect_obs("R2 wrap", 1'b1, 1'b1, 4'b0000, 4'b0101, 4'b0000);
    step(1);
    ser_tx_core = 1'b0;
    expect_obs("R3 mark", 1'b1, 1'b0, 4'b0000, 4'b0101, 4'b0000);
    step(1);
    ser_tx_core = 1'b1;
    ext_status = 4'b0100;
    step(3);
    expect_obs("R5 ext ignored", 1'b1, 1'b1, 4'b0000, 4'b0101, 4'b0000);
    step(1);
    mctl_bits = 4'b0001;
    expect_obs("R5 RI from bit2", 1'b1, 1'b1, 4'b0000, 4'b0001, 4'b0000);
    step(1);
    expect_obs("R8 loop RI fall", 1'b1, 1'b1, 4'b0000, 4'b0001, 4'b0100);
    step(1);
    read_clear("R9 clear loop RI", 1'b1, 1'b1, 4'b0000, 4'b0001);
    step(1);
    mctl_bits = 4'b1001;
    step(1);
    expect_obs("R5 CD from bit3", 1'b1, 1'b1, 4'b0000, 4'b1001, 4'b1000);
    step(1);
    read_clear("R9 clear loop CD", 1'b1, 1'b1, 4'b0000, 4'b1001);

    // Back to normal: synced 0100 vs prev 1001
    step(1);
    loop_en = 1'b0; ser_tx_core = 1'b0;
    expect_obs("R1 normal again", 1'b0, 1'b0, 4'b1001, 4'b0100, 4'b0000);
    step(1);
    expect_obs("R7 return flags", 1'b0, 1'b0, 4'b1001, 4'b0100, 4'b1001);

    step(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule